// File: doc/BRIEF.md
# Priority Ceiling Level Stack

This block holds the current execution priority level of a processor whose dispatcher is a hardware priority arbiter. Work is dispatched only when its priority is above this level. Every synchronization service comes down to raising the level and later putting it back. The services are resource locking under a stack-based ceiling protocol, masking of OS-visible interrupts, masking of all interrupts and locking out the scheduler. Each raise saves the old level on a bounded stack, and the matching lower command restores it.

A resource is named by its ceiling priority, so the acquire command carries the ceiling as its argument. A schedule point lowers the level to the task's base priority for exactly one cycle and then puts it back, so that any higher pending work can be taken by the arbiter. A task that must not be preempted runs under the scheduler lock, which raises the level to the highest task priority. Pushing onto a full stack or popping an empty one sets a sticky error flag.

Top module: `pcl_level_stack`

## Requirements
- R1: After reset the level output is 0, the error flag is 0 and the stack is empty.
- R2: Acquire (command code 1, argument = ceiling) sets the level to the larger of the ceiling and the current level. The registered level shows the change in the cycle after the command.
- R3: An acquire whose ceiling is at or below the current level leaves the level unchanged, but it still saves an entry so that its release stays balanced.
- R4: Every lowering command pops the most recently saved level and makes it the current level, so nested raises unwind in last-in, first-out order. The lowering commands are release (2), resume OS interrupts (4), resume all interrupts (6) and scheduler unlock (8).
- R5: Suspend OS interrupts (code 3) saves the level and raises it to at least OS_TOP, the highest OS-visible interrupt priority.
- R6: Suspend all interrupts (code 5) saves the level and raises it to at least ALL_TOP, the highest interrupt priority of any kind, which lies above all task and OS-visible priorities.
- R7: Scheduler lock (code 7), also used to start a task that must not be preempted, saves the level and raises it to at least TASK_TOP, the highest task priority.
- R8: A raising command while DEPTH entries are saved sets the error flag and changes neither the level nor the stack.
- R9: A lowering command while the stack is empty sets the error flag and leaves the level unchanged.
- R10: The error flag stays set until reset.
- R11: Schedule point (code 9, argument = base priority) sets the level to the smaller of the base and the current level for one cycle. In the next cycle it restores the previous level, and the stack is not touched.
- R12: A command presented in the cycle in which a schedule point is lowering the level is ignored.
- R13: Command codes 0 and 10 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_i | input | 4 | Command code |
| arg_i | input | LVL_W | Ceiling for acquire, base priority for schedule point |
| level_o | output | LVL_W | Current priority level, compared by the arbiter |
| err_o | output | 1 | Sticky stack overflow or underflow error |

## Verification
The hardest state to reach is a stack filled to exactly DEPTH entries whose saved values are all distinct. Only then does an overflow prove that neither the level nor the saved entries moved. The directed part fills the stack with strictly rising ceilings, overflows it, and pops once to show that the top entry survived. A second awkward case is a command that lands in the single lowering cycle of a schedule point. The bench issues an acquire right behind the schedule point and then unwinds the stack to show that nothing was pushed. The random phase resets at intervals so that the sticky error does not mask the later checks.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_ACQUIRE   = 4'd1,
    CMD_RELEASE   = 4'd2,
    CMD_OS_MASK   = 4'd3,
    CMD_OS_UNMASK = 4'd4,
    CMD_ALL_MASK  = 4'd5,
    CMD_ALL_UNMASK= 4'd6,
    CMD_SCHED_LOCK= 4'd7,
    CMD_SCHED_FREE= 4'd8,
    CMD_SCHED_PT  = 4'd9
  } cmd_e;
endpackage

// File: rtl/pcl_decode.sv
module pcl_decode
  import pcl_pkg::*;
#(
  parameter int LVL_W    = 4,
  parameter int TASK_TOP = 8,
  parameter int OS_TOP   = 11,
  parameter int ALL_TOP  = 15
) (
  input  logic [3:0]       cmd_i,
  input  logic [LVL_W-1:0] arg_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             dip_o,
  output logic [LVL_W-1:0] raise_o,
  output logic [LVL_W-1:0] dip_lvl_o
);
  localparam logic [LVL_W-1:0] TaskL = LVL_W'(TASK_TOP);
  localparam logic [LVL_W-1:0] OsL   = LVL_W'(OS_TOP);
  localparam logic [LVL_W-1:0] AllL  = LVL_W'(ALL_TOP);

  logic [LVL_W-1:0] tgt;

  always_comb begin
    push_o = 1'b0;
    pop_o  = 1'b0;
    dip_o  = 1'b0;
    tgt    = lvl_i;
    case (cmd_e'(cmd_i))
      CMD_ACQUIRE:    begin push_o = 1'b1; tgt = arg_i; end
      CMD_OS_MASK:    begin push_o = 1'b1; tgt = OsL;   end
      CMD_ALL_MASK:   begin push_o = 1'b1; tgt = AllL;  end
      CMD_SCHED_LOCK: begin push_o = 1'b1; tgt = TaskL; end
      CMD_RELEASE,
      CMD_OS_UNMASK,
      CMD_ALL_UNMASK,
      CMD_SCHED_FREE: pop_o = 1'b1;
      CMD_SCHED_PT:   dip_o = 1'b1;
      default:        ;
    endcase
  end

  // raises never lower the level
  assign raise_o   = (tgt > lvl_i) ? tgt : lvl_i;
  assign dip_lvl_o = (arg_i < lvl_i) ? arg_i : lvl_i;
endmodule

// File: rtl/pcl_stack.sv
module pcl_stack #(
  parameter int LVL_W = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] data_i,
  output logic [LVL_W-1:0] top_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]            cnt_q;
  logic [DEPTH-1:0][LVL_W-1:0] mem;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [LVL_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ent_q <= '0;
      else if (push_i && cnt_q == CNT_W'(g))   ent_q <= data_i;
    end
    assign mem[g] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (push_i)  cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i)   cnt_q <= cnt_q - CNT_W'(1);
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CNT_W'(i + 1)) top_o = mem[i];
  end

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/pcl_level_stack.sv
module pcl_level_stack #(
  parameter int LVL_W    = 4,
  parameter int DEPTH    = 8,
  parameter int TASK_TOP = 8,
  parameter int OS_TOP   = 11,
  parameter int ALL_TOP  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_i,
  input  logic [LVL_W-1:0] arg_i,
  output logic [LVL_W-1:0] level_o,
  output logic             err_o
);
  logic [LVL_W-1:0] level_q, saved_q, raise_w, dip_lvl_w, top_w;
  logic             dip_q, err_q;
  logic             push_w, pop_w, dip_w, full_w, empty_w;
  logic             act, push_ok, pop_ok, bad;

  pcl_decode #(
    .LVL_W(LVL_W), .TASK_TOP(TASK_TOP), .OS_TOP(OS_TOP), .ALL_TOP(ALL_TOP)
  ) u_dec (
    .cmd_i(cmd_i), .arg_i(arg_i), .lvl_i(level_q),
    .push_o(push_w), .pop_o(pop_w), .dip_o(dip_w),
    .raise_o(raise_w), .dip_lvl_o(dip_lvl_w)
  );

  // commands are dropped during the schedule-point dip
  assign act     = cmd_valid_i && !dip_q;
  assign push_ok = act && push_w && !full_w;
  assign pop_ok  = act && pop_w && !empty_w;
  assign bad     = act && ((push_w && full_w) || (pop_w && empty_w));

  pcl_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_stk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push_ok), .pop_i(pop_ok), .data_i(level_q),
    .top_o(top_w), .full_o(full_w), .empty_o(empty_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      saved_q <= '0;
      dip_q   <= 1'b0;
    end else if (dip_q) begin
      level_q <= saved_q;
      dip_q   <= 1'b0;
    end else if (push_ok) begin
      level_q <= raise_w;
    end else if (pop_ok) begin
      level_q <= top_w;
    end else if (act && dip_w) begin
      saved_q <= level_q;
      level_q <= dip_lvl_w;
      dip_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  assign level_o = level_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pcl_level_stack_chk.sv
module pcl_level_stack_chk #(
  parameter int LVL_W    = 4,
  parameter int TASK_TOP = 8,
  parameter int OS_TOP   = 11,
  parameter int ALL_TOP  = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [3:0]       cmd_i,
  input logic [LVL_W-1:0] arg_i,
  input logic [LVL_W-1:0] level_o,
  input logic             err_o,
  input logic             dip_q,
  input logic             full_w,
  input logic             empty_w
);
  localparam logic [LVL_W-1:0] OsL  = LVL_W'(OS_TOP);
  localparam logic [LVL_W-1:0] AllL = LVL_W'(ALL_TOP);
  localparam logic [LVL_W-1:0] TskL = LVL_W'(TASK_TOP);

  logic live, is_push, is_pop;
  assign live    = cmd_valid_i && !dip_q;
  assign is_push = (cmd_i == 4'd1) || (cmd_i == 4'd3) || (cmd_i == 4'd5) || (cmd_i == 4'd7);
  assign is_pop  = (cmd_i == 4'd2) || (cmd_i == 4'd4) || (cmd_i == 4'd6) || (cmd_i == 4'd8);

  a_r2_acquire_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_i == 4'd1 && !full_w) |=>
      level_o == (($past(arg_i) > $past(level_o)) ? $past(arg_i) : $past(level_o)));

  a_r3_push_never_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && is_push) |=> level_o >= $past(level_o));

  a_r5_os_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_i == 4'd3 && !full_w) |=> level_o >= OsL);

  a_r6_all_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_i == 4'd5 && !full_w) |=> level_o == AllL);

  a_r7_sched_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_i == 4'd7 && !full_w) |=> level_o >= TskL);

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && is_push && full_w) |=> (err_o && $stable(level_o)));

  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && is_pop && empty_w) |=> (err_o && $stable(level_o)));

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r11_dip_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_i == 4'd9) |=> ##1 (level_o == $past(level_o, 2)));

  a_r11_dip_not_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_i == 4'd9) |=> level_o <= $past(level_o));
endmodule

bind pcl_level_stack pcl_level_stack_chk #(
  .LVL_W(LVL_W), .TASK_TOP(TASK_TOP), .OS_TOP(OS_TOP), .ALL_TOP(ALL_TOP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .arg_i(arg_i), .level_o(level_o), .err_o(err_o),
  .dip_q(dip_q), .full_w(full_w), .empty_w(empty_w)
);

// File: tb/pcl_level_stack_tb.sv
`timescale 1ns/1ps
module pcl_level_stack_tb;
  localparam int LVL_W = 4, DEPTH = 8, TASK_TOP = 8, OS_TOP = 11, ALL_TOP = 15;

  logic clk = 1'b0, rst_ni = 1'b0, cmd_valid = 1'b0;
  logic [3:0] cmd = '0;
  logic [LVL_W-1:0] arg = '0, level;
  logic err;
  int checks = 0, errors = 0;
  bit done = 0;

  int mstk [DEPTH];
  int mcnt, mlvl, msaved;
  bit merr, mdip;

  always #5 clk = ~clk;

  pcl_level_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH), .TASK_TOP(TASK_TOP),
                    .OS_TOP(OS_TOP), .ALL_TOP(ALL_TOP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .arg_i(arg), .level_o(level), .err_o(err));

  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction

  task automatic model_reset();
    mcnt = 0; mlvl = 0; msaved = 0; merr = 0; mdip = 0;
  endtask

  task automatic model_step(bit v, int c, int a);
    int tgt;
    if (mdip) begin
      mlvl = msaved; mdip = 0;
    end else if (v) begin
      if (c == 1 || c == 3 || c == 5 || c == 7) begin
        tgt = (c == 1) ? a : (c == 3) ? OS_TOP : (c == 5) ? ALL_TOP : TASK_TOP;
        if (mcnt == DEPTH) merr = 1;
        else begin mstk[mcnt] = mlvl; mcnt++; mlvl = imax(mlvl, tgt); end
      end else if (c == 2 || c == 4 || c == 6 || c == 8) begin
        if (mcnt == 0) merr = 1;
        else begin mcnt--; mlvl = mstk[mcnt]; end
      end else if (c == 9) begin
        msaved = mlvl; mlvl = imin(a, mlvl); mdip = 1;
      end
    end
  endtask

  task automatic chk(string tag);
    checks++;
    if (int'(level) != mlvl || err !== merr) begin
      errors++;
      $display("FAIL %s: level=%0d err=%0b expected level=%0d err=%0b",
               tag, level, err, mlvl, merr);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1; model_reset();
    @(negedge clk);
  endtask

  task automatic issue(bit v, int c, int a, string tag);
    cmd_valid = v; cmd = 4'(c); arg = LVL_W'(a);
    model_step(v, c, a);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: level=%0d err=%0b expected finish", level, err);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'h1d5e);
    model_reset();
    do_reset();
    chk("R1 reset");
    issue(1, 1, 5, "R2 acquire 5");
    issue(1, 1, 3, "R3 acquire below");
    issue(1, 1, 9, "R2 acquire 9");
    issue(1, 2, 0, "R4 release to 5");
    issue(1, 2, 0, "R3 balanced release");
    issue(1, 2, 0, "R4 release to 0");
    issue(1, 3, 0, "R5 os mask");
    issue(1, 5, 0, "R6 all mask");
    issue(1, 3, 0, "R5 os mask under all");
    issue(1, 4, 0, "R4 os unmask");
    issue(1, 6, 0, "R4 all unmask");
    issue(1, 4, 0, "R4 os unmask to 0");
    issue(1, 7, 0, "R7 sched lock");
    issue(1, 1, 4, "R3 acquire under lock");
    issue(1, 2, 0, "R4 release under lock");
    issue(1, 8, 0, "R4 sched free");
    issue(1, 1, 6, "R2 acquire 6");
    issue(1, 9, 2, "R11 sched point dip");
    issue(1, 1, 14, "R12 acquire during dip");
    issue(0, 0, 0, "R11 level restored");
    issue(1, 9, 12, "R11 base above level");
    issue(0, 0, 0, "R11 restore after high base");
    issue(1, 12, 7, "R13 unknown code");
    issue(1, 0, 9, "R13 nop code");
    issue(1, 2, 0, "R12 one entry only");
    issue(1, 2, 0, "R9 underflow");
    issue(1, 1, 3, "R10 err sticky");
    do_reset();
    chk("R1 second reset");
    for (int i = 1; i <= DEPTH; i++) issue(1, 1, i, "R2 fill stack");
    issue(1, 1, 15, "R8 overflow");
    issue(1, 5, 0, "R8 overflow mask");
    issue(1, 2, 0, "R8 top entry kept");
    for (int n = 0; n < 3000; n++) begin
      if (n % 300 == 0) do_reset();
      issue(($urandom % 5) != 0, int'($urandom % 11), int'($urandom % 16), "random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule